// File: doc/BRIEF.md
# I2C Bus Timeout Supervisor

This block supervises a two-wire serial bus and flags activity that lasts too long. It observes the clock line and decoded start and stop strobes. Its timebase has two stages. A microsecond tick is divided down from the core clock, and a millisecond tick is divided down from the microsecond tick. Every timeout period therefore scales directly with the core clock period.

Three independent timers run from this timebase. The clock-low timer counts microsecond ticks while the clock line is held low. The arbitration timer counts millisecond ticks while the local master waits to win the bus. The transaction timer counts millisecond ticks from a start condition to the next stop condition. A limit of zero turns a timer off. The clock-low timer is held off while a boot load is running. Each expiry sets a sticky flag, which software clears by pulsing a per-flag clear bit.

Top module: `i2c_tmo_supervisor`

## Requirements
- R1: `us_tick` is a one-cycle pulse, and pulses are spaced `us_div + 1` core clocks apart.
- R2: `ms_tick` pulses only in cycles where `us_tick` pulses, once every `ms_div + 1` microsecond ticks.
- R3: A new divider value takes effect only after the next tick of that divider. The tick period already in progress keeps the old length.
- R4: The clock line passes through a two-stage synchronizer. The clock-low timer counts microsecond ticks while the synchronized line is low and restarts at zero each time the line goes high. `scl_low_flag` rises the cycle after the counted tick that brings the count to `scl_low_lim`.
- R5: A timer whose limit is zero never counts and never sets its flag.
- R6: While `boot_busy` is high the clock-low timer is held at zero. It starts counting from zero when `boot_busy` falls.
- R7: The arbitration timer counts millisecond ticks while `arb_wait` is high and clears when `arb_wait` is low. `arb_flag` rises the cycle after the count reaches `arb_lim`.
- R8: The transaction timer starts counting in the cycle after `start_evt` and clears when `stop_evt` arrives. A start that comes while the timer is already running (repeated start) does not restart it. `tran_flag` rises the cycle after the count reaches `tran_lim`.
- R9: Flags are sticky. Bit 0 of `flag_clr` clears `scl_low_flag`, bit 1 clears `arb_flag` and bit 2 clears `tran_flag`, each without touching the others. A flag cleared while its timer is still saturated stays clear until that timer restarts.
- R10: After reset all three flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_line | input | 1 | Bus clock line (asynchronous) |
| start_evt | input | 1 | One-cycle strobe: start condition seen |
| stop_evt | input | 1 | One-cycle strobe: stop condition seen |
| boot_busy | input | 1 | High while a boot load is in progress |
| arb_wait | input | 1 | High while the local master waits for the bus |
| us_div | input | DIV_W | Microsecond divider; period is value + 1 clocks |
| ms_div | input | DIV_W | Millisecond divider; period is value + 1 microsecond ticks |
| scl_low_lim | input | CNT_W | Clock-low limit in microsecond ticks, 0 = off |
| arb_lim | input | CNT_W | Arbitration limit in millisecond ticks, 0 = off |
| tran_lim | input | CNT_W | Transaction limit in millisecond ticks, 0 = off |
| flag_clr | input | 3 | Write-one-to-clear pulses for the flags |
| us_tick | output | 1 | Microsecond tick pulse |
| ms_tick | output | 1 | Millisecond tick pulse |
| scl_low_flag | output | 1 | Sticky clock-low timeout |
| arb_flag | output | 1 | Sticky arbitration timeout |
| tran_flag | output | 1 | Sticky transaction timeout |

## Verification
The assertions assume the following about the inputs:
- `start_evt`, `stop_evt`, `arb_wait`, `boot_busy` and `flag_clr` are synchronous to the core clock.
- Limits only change while the timer they govern is idle, so a flag can rise only on a counted tick with a nonzero limit.

The stimulus keeps to these assumptions. It drives every input on the falling clock edge, and it changes limits and dividers only while the affected timer is stopped or while measuring the divider's own boundary behaviour.

// File: rtl/i2c_tmo_pkg.sv
package i2c_tmo_pkg;
   localparam int TMO_COUNT = 3;

   typedef enum int {
      TMO_SCL_LOW = 0,
      TMO_ARB     = 1,
      TMO_TRAN    = 2
   } tmo_id_e;

   typedef enum logic {
      BASE_US = 1'b0,
      BASE_MS = 1'b1
   } tmo_base_e;

   // Which tick each timer counts
   function automatic tmo_base_e tmo_base(input int id);
      return (id == TMO_SCL_LOW) ? BASE_US : BASE_MS;
   endfunction

   // Which timers are held off during a boot load
   function automatic bit tmo_boot_gated(input int id);
      return (id == TMO_SCL_LOW);
   endfunction
endpackage

// File: rtl/i2c_tmo_sync.sv
module i2c_tmo_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q_o = d_i;
      end else begin : g_chain
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], d_i};
         end
         assign q_o = chain[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/tmo_prescaler.sv
module tmo_prescaler #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic [W-1:0] div_i,
   output logic         tick_o
);
   logic [W-1:0] cnt;
   logic [W-1:0] div_q;
   logic         armed;
   logic         at_end;

   assign at_end = armed && (cnt == div_q);
   assign tick_o = en && at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         div_q <= '0;
         armed <= 1'b0;
      end else if (!armed) begin
         div_q <= div_i;
         armed <= 1'b1;
      end else if (en) begin
         if (at_end) begin
            cnt   <= '0;
            div_q <= div_i;   // new period only at a boundary
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/tmo_timer.sv
module tmo_timer #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             active,
   input  logic [CNT_W-1:0] limit,
   input  logic             clr,
   output logic             flag_o
);
   logic [CNT_W-1:0] cnt;
   logic             run;
   logic             hit;

   assign run = active && (limit != '0);
   assign hit = run && tick && (cnt == limit - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         flag_o <= 1'b0;
      end else begin
         if (!run)                      cnt <= '0;
         else if (tick && cnt < limit)  cnt <= cnt + 1'b1;
         if (hit)      flag_o <= 1'b1;
         else if (clr) flag_o <= 1'b0;
      end
   end
endmodule

// File: rtl/i2c_tmo_supervisor.sv
module i2c_tmo_supervisor
   import i2c_tmo_pkg::*;
#(
   parameter int DIV_W       = 16,
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_line,
   input  logic             start_evt,
   input  logic             stop_evt,
   input  logic             boot_busy,
   input  logic             arb_wait,
   input  logic [DIV_W-1:0] us_div,
   input  logic [DIV_W-1:0] ms_div,
   input  logic [CNT_W-1:0] scl_low_lim,
   input  logic [CNT_W-1:0] arb_lim,
   input  logic [CNT_W-1:0] tran_lim,
   input  logic [2:0]       flag_clr,
   output logic             us_tick,
   output logic             ms_tick,
   output logic             scl_low_flag,
   output logic             arb_flag,
   output logic             tran_flag
);
   localparam int NT = TMO_COUNT;

   generate
      if (DIV_W < 2 || DIV_W > 32) begin : g_bad_div
         $error("DIV_W out of range");
      end
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt
         $error("CNT_W out of range");
      end
      if (SYNC_STAGES == 1 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must be 0 or 2..4");
      end
   endgenerate

   logic scl_s;
   logic busy;

   i2c_tmo_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i(scl_line), .q_o(scl_s)
   );

   tmo_prescaler #(.W(DIV_W)) u_us (
      .clk(clk), .rst_n(rst_n), .en(1'b1), .div_i(us_div), .tick_o(us_tick)
   );

   tmo_prescaler #(.W(DIV_W)) u_ms (
      .clk(clk), .rst_n(rst_n), .en(us_tick), .div_i(ms_div), .tick_o(ms_tick)
   );

   // Transaction window: opened by start, closed by stop
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         busy <= 1'b0;
      else if (stop_evt)  busy <= 1'b0;
      else if (start_evt) busy <= 1'b1;
   end

   logic [NT-1:0]    raw_act;
   logic [NT-1:0]    t_tick;
   logic [NT-1:0]    t_flag;
   logic [CNT_W-1:0] t_lim [NT];

   assign raw_act[TMO_SCL_LOW] = ~scl_s;
   assign raw_act[TMO_ARB]     = arb_wait;
   assign raw_act[TMO_TRAN]    = busy;
   assign t_lim[TMO_SCL_LOW]   = scl_low_lim;
   assign t_lim[TMO_ARB]       = arb_lim;
   assign t_lim[TMO_TRAN]      = tran_lim;

   generate
      for (genvar i = 0; i < NT; i++) begin : g_tmo
         localparam tmo_base_e BASE  = tmo_base(i);
         localparam bit        GATED = tmo_boot_gated(i);
         logic act;

         if (BASE == BASE_US) begin : g_us
            assign t_tick[i] = us_tick;
         end else begin : g_ms
            assign t_tick[i] = ms_tick;
         end

         if (GATED) begin : g_gate
            assign act = raw_act[i] & ~boot_busy;
         end else begin : g_free
            assign act = raw_act[i];
         end

         tmo_timer #(.CNT_W(CNT_W)) u_tmr (
            .clk(clk), .rst_n(rst_n), .tick(t_tick[i]), .active(act),
            .limit(t_lim[i]), .clr(flag_clr[i]), .flag_o(t_flag[i])
         );
      end
   endgenerate

   assign scl_low_flag = t_flag[TMO_SCL_LOW];
   assign arb_flag     = t_flag[TMO_ARB];
   assign tran_flag    = t_flag[TMO_TRAN];
endmodule

// File: rtl/i2c_tmo_checker.sv
module i2c_tmo_checker #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             us_tick,
   input logic             ms_tick,
   input logic             boot_busy,
   input logic             arb_wait,
   input logic [CNT_W-1:0] scl_low_lim,
   input logic [2:0]       flag_clr,
   input logic             scl_low_flag,
   input logic             arb_flag,
   input logic             tran_flag
);
   AST_MS_ON_US: assert property (@(posedge clk) disable iff (!rst_n)
      ms_tick |-> us_tick);                                              // R2
   AST_SCL_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(scl_low_flag) |-> $past(us_tick));                           // R4
   AST_SCL_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(scl_low_flag) |-> $past(scl_low_lim) != '0);                 // R5
   AST_BOOT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(scl_low_flag) |-> !$past(boot_busy));                        // R6
   AST_ARB_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(arb_flag) |-> $past(arb_wait && ms_tick));                   // R7
   AST_TRAN_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tran_flag) |-> $past(ms_tick));                              // R8
   AST_SCL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_low_flag && !flag_clr[0]) |=> scl_low_flag);                  // R9
   AST_ARB_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (arb_flag && !flag_clr[1]) |=> arb_flag);                          // R9
   AST_TRAN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (tran_flag && !flag_clr[2]) |=> tran_flag);                        // R9
endmodule

bind i2c_tmo_supervisor i2c_tmo_checker #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .ms_tick(ms_tick),
   .boot_busy(boot_busy), .arb_wait(arb_wait), .scl_low_lim(scl_low_lim),
   .flag_clr(flag_clr), .scl_low_flag(scl_low_flag), .arb_flag(arb_flag),
   .tran_flag(tran_flag)
);

// File: tb/tb_i2c_tmo_supervisor.sv
module tb_i2c_tmo_supervisor;
   localparam int DW = 16;
   localparam int CW = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_line = 1'b1, start_evt = 1'b0, stop_evt = 1'b0;
   logic boot_busy = 1'b0, arb_wait = 1'b0;
   logic [DW-1:0] us_div = 16'd3, ms_div = 16'd1;
   logic [CW-1:0] scl_low_lim = 16'd5, arb_lim = 16'd2, tran_lim = 16'd4;
   logic [2:0] flag_clr = 3'b000;
   logic us_tick, ms_tick, scl_low_flag, arb_flag, tran_flag;

   int errors = 0;
   int checks = 0;
   int cyc = 0;

   always #5 clk = ~clk;

   i2c_tmo_supervisor #(.DIV_W(DW), .CNT_W(CW), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .scl_line(scl_line), .start_evt(start_evt),
      .stop_evt(stop_evt), .boot_busy(boot_busy), .arb_wait(arb_wait),
      .us_div(us_div), .ms_div(ms_div), .scl_low_lim(scl_low_lim),
      .arb_lim(arb_lim), .tran_lim(tran_lim), .flag_clr(flag_clr),
      .us_tick(us_tick), .ms_tick(ms_tick), .scl_low_flag(scl_low_flag),
      .arb_flag(arb_flag), .tran_flag(tran_flag)
   );

   // {us_div, ms_div} pairs for the timebase table walk
   localparam logic [31:0] VEC [4] = '{
      {16'd3, 16'd1}, {16'd0, 16'd2}, {16'd5, 16'd0}, {16'd1, 16'd3}
   };

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=%0d cycles expected<=150000", cyc);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic tick_of(input int base);
      return (base == 0) ? us_tick : ms_tick;
   endfunction

   function automatic logic flag_of(input int id);
      case (id)
         0: return scl_low_flag;
         1: return arb_flag;
         default: return tran_flag;
      endcase
   endfunction

   // Cycles between two successive ticks of one base
   task automatic meas(input int base, output int p);
      int g = 0;
      p = 0;
      while (!tick_of(base) && g < 5000) begin @(negedge clk); g++; end
      do begin @(negedge clk); p++; end while (!tick_of(base) && p < 5000);
   endtask

   // Count k ticks starting with the current sample
   task automatic wait_ticks(input int base, input int k);
      int n = 0, g = 0;
      forever begin
         if (tick_of(base)) n++;
         if (n >= k || g > 20000) break;
         @(negedge clk); g++;
      end
   endtask

   // Flag must stay low until the lim-th counted tick, then rise next cycle
   task automatic run_expire(input int base, input int id, input int lim, input string req);
      int n = 0, g = 0, early = 0;
      forever begin
         if (flag_of(id)) early = 1;
         if (tick_of(base)) n++;
         if (n >= lim || g > 20000) break;
         @(negedge clk); g++;
      end
      check({req, " flag low before limit"}, early, 0);
      @(negedge clk);
      check({req, " flag set after limit"}, int'(flag_of(id)), 1);
   endtask

   initial begin
      int p;
      repeat (3) @(negedge clk);
      // R10: reset state
      check("R10 flags after reset", int'({scl_low_flag, arb_flag, tran_flag}), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1/R2: table walk over divider settings
      foreach (VEC[i]) begin
         us_div = VEC[i][31:16];
         ms_div = VEC[i][15:0];
         meas(0, p); meas(0, p);
         check("R1 us period", p, int'(VEC[i][31:16]) + 1);
         meas(1, p); meas(1, p); meas(1, p);
         check("R2 ms period", p, (int'(VEC[i][15:0]) + 1) * (int'(VEC[i][31:16]) + 1));
      end

      // R3: change at boundary
      us_div = 16'd3; ms_div = 16'd1;
      meas(0, p); meas(0, p);
      @(negedge clk); us_div = 16'd7; p = 1;
      while (!us_tick && p < 100) begin @(negedge clk); p++; end
      check("R3 old period kept", p, 4);
      meas(0, p);
      check("R3 new period used", p, 8);
      us_div = 16'd3;
      meas(0, p); meas(0, p);
      @(negedge clk);

      // R4: clock-low expiry, restart on high
      scl_line = 1'b0; @(negedge clk); @(negedge clk);
      wait_ticks(0, 3);
      @(negedge clk); scl_line = 1'b1;
      repeat (4) @(negedge clk);
      check("R4 no flag before restart", int'(scl_low_flag), 0);
      scl_line = 1'b0; @(negedge clk); @(negedge clk);
      run_expire(0, 0, 5, "R4 restart then expire");
      scl_line = 1'b1;
      repeat (10) @(negedge clk);
      check("R9 flag sticky after line high", int'(scl_low_flag), 1);

      // R7: arbitration
      arb_wait = 1'b1;
      run_expire(1, 1, 2, "R7 arbitration");
      arb_wait = 1'b0;

      // R9: per-bit clear
      flag_clr = 3'b001; @(negedge clk); flag_clr = 3'b000;
      check("R9 bit0 clears scl flag", int'(scl_low_flag), 0);
      check("R9 bit0 leaves arb flag", int'(arb_flag), 1);
      flag_clr = 3'b010; @(negedge clk); flag_clr = 3'b000;
      check("R9 bit1 clears arb flag", int'(arb_flag), 0);

      // R9: clear while saturated stays clear
      scl_line = 1'b0; @(negedge clk); @(negedge clk);
      run_expire(0, 0, 5, "R4 second expiry");
      flag_clr = 3'b001; @(negedge clk); flag_clr = 3'b000;
      wait_ticks(0, 12); @(negedge clk);
      check("R9 stays clear while saturated", int'(scl_low_flag), 0);
      scl_line = 1'b1; repeat (4) @(negedge clk);

      // R5: zero limit disables
      scl_low_lim = '0; arb_lim = '0;
      scl_line = 1'b0; arb_wait = 1'b1;
      wait_ticks(1, 6); @(negedge clk);
      check("R5 zero limit clock-low", int'(scl_low_flag), 0);
      check("R5 zero limit arbitration", int'(arb_flag), 0);
      scl_line = 1'b1; arb_wait = 1'b0;
      scl_low_lim = 16'd5; arb_lim = 16'd2;
      repeat (4) @(negedge clk);

      // R6: boot suppression
      boot_busy = 1'b1; scl_line = 1'b0;
      wait_ticks(0, 10); @(negedge clk);
      check("R6 held during boot", int'(scl_low_flag), 0);
      boot_busy = 1'b0;
      run_expire(0, 0, 5, "R6 counts from boot end");
      scl_line = 1'b1;
      flag_clr = 3'b001; @(negedge clk); flag_clr = 3'b000;

      // R8: repeated start does not restart
      start_evt = 1'b1; @(negedge clk); start_evt = 1'b0;
      wait_ticks(1, 2);
      @(negedge clk); start_evt = 1'b1;
      fork begin @(negedge clk); start_evt = 1'b0; end join_none
      run_expire(1, 2, 2, "R8 repeated start");
      // stop clears
      stop_evt = 1'b1; @(negedge clk); stop_evt = 1'b0;
      flag_clr = 3'b100; @(negedge clk); flag_clr = 3'b000;
      start_evt = 1'b1; @(negedge clk); start_evt = 1'b0;
      wait_ticks(1, 2);
      @(negedge clk); stop_evt = 1'b1; @(negedge clk); stop_evt = 1'b0;
      wait_ticks(1, 4); @(negedge clk);
      check("R8 stop clears timer", int'(tran_flag), 0);
      start_evt = 1'b1; @(negedge clk); start_evt = 1'b0;
      run_expire(1, 2, 4, "R8 fresh transaction");
      stop_evt = 1'b1; @(negedge clk); stop_evt = 1'b0;

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule